// File: doc/BRIEF.md
# UART Interrupt and DMA Request Router

This block sits beside a serial port's receiver and transmitter and decides, event by event, whether that event becomes an interrupt request or a DMA request. It holds the port's enable bits in one 32-bit register image. Software sets the bits through a write-one-to-set port. It clears them through a write-one-to-clear port. Either register offset reads back the same enable image.

Error events, wakeup and break each latch their own interrupt line when enabled. Receive-ready events are steered frame by frame. With receive DMA off, every frame goes to the receive interrupt. With receive DMA on and the all-frames bit off, address frames go to the interrupt and data frames go to DMA. With both bits on, every frame goes to DMA. Transmit-ready goes to DMA when transmit DMA is enabled, and to the transmit interrupt otherwise.

Each interrupt line is a two-state machine per source. SRC_IDLE moves to SRC_PEND on a qualified event (transition `raise`). SRC_PEND returns to SRC_IDLE on an acknowledge with no new event in the same cycle (transition `retire`). In every other case the state holds. Receive routing is decoded into RX_ROUTE_NONE, RX_ROUTE_IRQ or RX_ROUTE_DMA. Transmit routing is decoded into TX_ROUTE_NONE, TX_ROUTE_IRQ or TX_ROUTE_DMA. Routing uses the enable image as it stood before the current clock edge.

Top module: `uart_irq_router`

## Requirements
- R1: After reset, every enable bit, every interrupt line and both DMA strobes are 0.
- R2: A set-port write sets each implemented enable bit whose data bit is 1 and leaves the bits written 0 unchanged. The implemented bits are break 0, wakeup 1, transmit interrupt 8, receive interrupt 9, transmit DMA 16, receive DMA 17, receive-DMA-all 18, parity 24, overrun 25 and framing 26.
- R3: A clear-port write clears each enable bit whose data bit is 1 and leaves the bits written 0 unchanged.
- R4: When a set and a clear name the same bit in the same cycle, the bit ends up 0.
- R5: Bits 31-27, 23-19, 15-10 and 7-2 always read 0, and writes to them have no effect.
- R6: Reading address 0x0C or 0x10 returns the current enable image. Any other read address returns 0. The read path is combinational.
- R7: A framing, overrun or parity event raises its interrupt line one cycle later only if its enable is 1. The line indices are break 0, wakeup 1, transmit 2, receive 3, parity 4, overrun 5 and framing 6.
- R8: An interrupt line stays high until its acknowledge bit is pulsed. If an event and an acknowledge for the same line fall in the same cycle, the line stays high.
- R9: With receive DMA 0, every received frame raises the receive interrupt, gated by the receive interrupt enable.
- R10: With receive DMA 1 and receive-DMA-all 0, an address frame raises the receive interrupt (gated by its enable) and a data frame raises a receive DMA strobe.
- R11: With receive DMA 1 and receive-DMA-all 1, every frame raises a receive DMA strobe and no receive interrupt.
- R12: With transmit DMA 1, transmit-ready raises a transmit DMA strobe. Otherwise it raises the transmit interrupt, gated by the transmit interrupt enable.
- R13: Wakeup and break events raise their interrupt lines only when their enables are 1.
- R14: Each DMA strobe is high for exactly one cycle, in the cycle after its event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_we | input | 1 | Write strobe of the set register |
| set_wdata | input | 32 | Write-one-to-set data |
| clr_we | input | 1 | Write strobe of the clear register |
| clr_wdata | input | 32 | Write-one-to-clear data |
| rd_addr | input | 8 | Byte read address |
| rd_data | output | 32 | Read data (enable image or 0) |
| ev_frame_err | input | 1 | Framing error event pulse |
| ev_overrun | input | 1 | Overrun event pulse |
| ev_parity_err | input | 1 | Parity error event pulse |
| ev_rx_ready | input | 1 | Received frame event pulse |
| ev_rx_is_addr | input | 1 | The received frame is an address frame |
| ev_tx_ready | input | 1 | Transmitter ready event pulse |
| ev_wakeup | input | 1 | Wakeup event pulse |
| ev_break | input | 1 | Break detect event pulse |
| irq_ack | input | 7 | Per-line interrupt acknowledge pulses |
| irq_req | output | 7 | Per-line interrupt request levels |
| rx_dma_req | output | 1 | Receive DMA request strobe |
| tx_dma_req | output | 1 | Transmit DMA request strobe |

## Verification
Two pairs of functions can land in the same clock cycle. The first pair is a set write and a clear write that name the same enable bit. The second pair is a source event and that source's acknowledge. The bench provokes each pair on purpose by driving both ports in a single cycle. It judges the result one edge later: the shared enable bit must read back 0, and the interrupt line must still be high. A reference model in the scoreboard predicts both outcomes from the requirements alone.

// File: rtl/uirq_pkg.sv
`timescale 1ns/1ps
package uirq_pkg;

    localparam int REG_W = 32;

    localparam int EN_BRK    = 0;
    localparam int EN_WAKE   = 1;
    localparam int EN_TXINT  = 8;
    localparam int EN_RXINT  = 9;
    localparam int EN_TXDMA  = 16;
    localparam int EN_RXDMA  = 17;
    localparam int EN_RXALL  = 18;
    localparam int EN_PE     = 24;
    localparam int EN_OE     = 25;
    localparam int EN_FE     = 26;

    localparam int IRQ_BRK  = 0;
    localparam int IRQ_WAKE = 1;
    localparam int IRQ_TX   = 2;
    localparam int IRQ_RX   = 3;
    localparam int IRQ_PE   = 4;
    localparam int IRQ_OE   = 5;
    localparam int IRQ_FE   = 6;
    localparam int NUM_IRQ  = 7;

    function automatic logic [REG_W-1:0] impl_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[EN_BRK]   = 1'b1;
        m[EN_WAKE]  = 1'b1;
        m[EN_TXINT] = 1'b1;
        m[EN_RXINT] = 1'b1;
        m[EN_TXDMA] = 1'b1;
        m[EN_RXDMA] = 1'b1;
        m[EN_RXALL] = 1'b1;
        m[EN_PE]    = 1'b1;
        m[EN_OE]    = 1'b1;
        m[EN_FE]    = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] IMPL_MASK = impl_mask();

    typedef enum logic {
        SRC_IDLE,
        SRC_PEND
    } src_state_e;

    typedef enum logic [1:0] {
        ROUTE_NONE,
        ROUTE_IRQ,
        ROUTE_DMA
    } route_e;

    typedef struct packed {
        logic fe;
        logic oe;
        logic pe;
        logic rx_all;
        logic rx_dma;
        logic tx_dma;
        logic rx_int;
        logic tx_int;
        logic wake;
        logic brk;
    } en_view_t;

endpackage

// File: rtl/uirq_enable_reg.sv
`timescale 1ns/1ps
module uirq_enable_reg
    import uirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic [REG_W-1:0] set_wdata,
    input  logic             clr_we,
    input  logic [REG_W-1:0] clr_wdata,
    output logic [REG_W-1:0] en_q
);

    logic [REG_W-1:0] set_v;
    logic [REG_W-1:0] clr_v;
    logic [REG_W-1:0] en_d;

    // Clear is applied after set, so a clear beats a set on the same bit.
    always_comb begin
        set_v = set_we ? (set_wdata & IMPL_MASK) : '0;
        clr_v = clr_we ? clr_wdata : '0;
        en_d  = (en_q | set_v) & ~clr_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (set_we || clr_we) begin
            en_q <= en_d;
        end
    end

endmodule

// File: rtl/uirq_steer.sv
`timescale 1ns/1ps
module uirq_steer
    import uirq_pkg::*;
(
    input  en_view_t             en,
    input  logic                 ev_frame_err,
    input  logic                 ev_overrun,
    input  logic                 ev_parity_err,
    input  logic                 ev_rx_ready,
    input  logic                 ev_rx_is_addr,
    input  logic                 ev_tx_ready,
    input  logic                 ev_wakeup,
    input  logic                 ev_break,
    output logic [NUM_IRQ-1:0]   irq_hit,
    output logic                 rx_dma_hit,
    output logic                 tx_dma_hit
);

    route_e rx_route;
    route_e tx_route;

    // Receive route decode: data frames follow the DMA enable, address
    // frames need the all-frames bit as well.
    always_comb begin
        if (!ev_rx_ready) begin
            rx_route = ROUTE_NONE;
        end else if (en.rx_dma && (!ev_rx_is_addr || en.rx_all)) begin
            rx_route = ROUTE_DMA;
        end else begin
            rx_route = ROUTE_IRQ;
        end
    end

    always_comb begin
        if (!ev_tx_ready) begin
            tx_route = ROUTE_NONE;
        end else if (en.tx_dma) begin
            tx_route = ROUTE_DMA;
        end else begin
            tx_route = ROUTE_IRQ;
        end
    end

    always_comb begin
        irq_hit             = '0;
        rx_dma_hit          = 1'b0;
        tx_dma_hit          = 1'b0;
        irq_hit[IRQ_FE]     = ev_frame_err  && en.fe;
        irq_hit[IRQ_OE]     = ev_overrun    && en.oe;
        irq_hit[IRQ_PE]     = ev_parity_err && en.pe;
        irq_hit[IRQ_WAKE]   = ev_wakeup     && en.wake;
        irq_hit[IRQ_BRK]    = ev_break      && en.brk;
        unique case (rx_route)
            ROUTE_NONE: ;
            ROUTE_IRQ:  irq_hit[IRQ_RX] = en.rx_int;
            ROUTE_DMA:  rx_dma_hit      = 1'b1;
            default:    ;
        endcase
        unique case (tx_route)
            ROUTE_NONE: ;
            ROUTE_IRQ:  irq_hit[IRQ_TX] = en.tx_int;
            ROUTE_DMA:  tx_dma_hit      = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/uirq_src_cell.sv
`timescale 1ns/1ps
module uirq_src_cell
    import uirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ack,
    output logic irq
);

    src_state_e state_q;
    src_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SRC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // raise: IDLE -> PEND on hit; retire: PEND -> IDLE on ack without hit.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE: if (hit)         state_d = SRC_PEND;
            SRC_PEND: if (ack && !hit) state_d = SRC_IDLE;
            default:                   state_d = SRC_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == SRC_PEND);
    end

endmodule

// File: rtl/uart_irq_router.sv
`timescale 1ns/1ps
module uart_irq_router
    import uirq_pkg::*;
#(
    parameter int                AW      = 8,
    parameter logic [AW-1:0]     SET_OFS = 8'h0C,
    parameter logic [AW-1:0]     CLR_OFS = 8'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_we,
    input  logic [31:0]        set_wdata,
    input  logic               clr_we,
    input  logic [31:0]        clr_wdata,
    input  logic [AW-1:0]      rd_addr,
    output logic [31:0]        rd_data,
    input  logic               ev_frame_err,
    input  logic               ev_overrun,
    input  logic               ev_parity_err,
    input  logic               ev_rx_ready,
    input  logic               ev_rx_is_addr,
    input  logic               ev_tx_ready,
    input  logic               ev_wakeup,
    input  logic               ev_break,
    input  logic [6:0]         irq_ack,
    output logic [6:0]         irq_req,
    output logic               rx_dma_req,
    output logic               tx_dma_req
);

    logic [REG_W-1:0]   en_q;
    en_view_t           en_v;
    logic [NUM_IRQ-1:0] irq_hit;
    logic               rx_dma_hit;
    logic               tx_dma_hit;
    logic               rx_dma_q;
    logic               tx_dma_q;

    uirq_enable_reg u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_we    (set_we),
        .set_wdata (set_wdata),
        .clr_we    (clr_we),
        .clr_wdata (clr_wdata),
        .en_q      (en_q)
    );

    always_comb begin
        en_v.fe     = en_q[EN_FE];
        en_v.oe     = en_q[EN_OE];
        en_v.pe     = en_q[EN_PE];
        en_v.rx_all = en_q[EN_RXALL];
        en_v.rx_dma = en_q[EN_RXDMA];
        en_v.tx_dma = en_q[EN_TXDMA];
        en_v.rx_int = en_q[EN_RXINT];
        en_v.tx_int = en_q[EN_TXINT];
        en_v.wake   = en_q[EN_WAKE];
        en_v.brk    = en_q[EN_BRK];
    end

    uirq_steer u_steer (
        .en            (en_v),
        .ev_frame_err  (ev_frame_err),
        .ev_overrun    (ev_overrun),
        .ev_parity_err (ev_parity_err),
        .ev_rx_ready   (ev_rx_ready),
        .ev_rx_is_addr (ev_rx_is_addr),
        .ev_tx_ready   (ev_tx_ready),
        .ev_wakeup     (ev_wakeup),
        .ev_break      (ev_break),
        .irq_hit       (irq_hit),
        .rx_dma_hit    (rx_dma_hit),
        .tx_dma_hit    (tx_dma_hit)
    );

    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_src
        uirq_src_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (irq_hit[gi]),
            .ack   (irq_ack[gi]),
            .irq   (irq_req[gi])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_dma_q <= 1'b0;
            tx_dma_q <= 1'b0;
        end else begin
            rx_dma_q <= rx_dma_hit;
            tx_dma_q <= tx_dma_hit;
        end
    end

    assign rx_dma_req = rx_dma_q;
    assign tx_dma_req = tx_dma_q;

    always_comb begin
        if ((rd_addr == SET_OFS) || (rd_addr == CLR_OFS)) begin
            rd_data = en_q;
        end else begin
            rd_data = '0;
        end
    end

endmodule

// File: rtl/uart_irq_router_chk.sv
`timescale 1ns/1ps
module uart_irq_router_chk
    import uirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              set_we,
    input logic [REG_W-1:0]  set_wdata,
    input logic              clr_we,
    input logic [REG_W-1:0]  clr_wdata,
    input logic [REG_W-1:0]  rd_data,
    input logic [REG_W-1:0]  en_q,
    input logic              ev_rx_ready,
    input logic              ev_tx_ready,
    input logic [6:0]        irq_ack,
    input logic [6:0]        irq_req,
    input logic              rx_dma_req,
    input logic              tx_dma_req
);

    p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~IMPL_MASK) == '0);

    p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !clr_we) |=>
            ((en_q & $past(set_wdata & IMPL_MASK)) == $past(set_wdata & IMPL_MASK)));

    p_clear_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((en_q & $past(clr_wdata)) == '0));

    p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && clr_we) |=> ((en_q & $past(set_wdata & clr_wdata)) == '0));

    p_fe_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[EN_FE] && !irq_req[IRQ_FE]) |=> !irq_req[IRQ_FE]);

    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_hold
        p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req[gi] && !irq_ack[gi]) |=> irq_req[gi]);
    end

    p_rx_all_dma_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_ready && en_q[EN_RXDMA] && en_q[EN_RXALL] && !irq_req[IRQ_RX])
            |=> (rx_dma_req && !irq_req[IRQ_RX]));

    p_rx_strobe_cause_r14: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> $past(ev_rx_ready));

    p_tx_strobe_cause_r14: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> $past(ev_tx_ready));

endmodule

bind uart_irq_router uart_irq_router_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_we      (set_we),
    .set_wdata   (set_wdata),
    .clr_we      (clr_we),
    .clr_wdata   (clr_wdata),
    .rd_data     (rd_data),
    .en_q        (en_q),
    .ev_rx_ready (ev_rx_ready),
    .ev_tx_ready (ev_tx_ready),
    .irq_ack     (irq_ack),
    .irq_req     (irq_req),
    .rx_dma_req  (rx_dma_req),
    .tx_dma_req  (tx_dma_req)
);

// File: tb/uart_irq_router_tb.sv
`timescale 1ns/1ps
module uart_irq_router_tb;

    localparam logic [31:0] MASK = 32'h0707_0303;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_we = 1'b0;
    logic [31:0] set_wdata = '0;
    logic        clr_we = 1'b0;
    logic [31:0] clr_wdata = '0;
    logic [7:0]  rd_addr = 8'h0C;
    logic [31:0] rd_data;
    logic        ev_frame_err = 1'b0, ev_overrun = 1'b0, ev_parity_err = 1'b0;
    logic        ev_rx_ready = 1'b0, ev_rx_is_addr = 1'b0, ev_tx_ready = 1'b0;
    logic        ev_wakeup = 1'b0, ev_break = 1'b0;
    logic [6:0]  irq_ack = '0;
    logic [6:0]  irq_req;
    logic        rx_dma_req, tx_dma_req;

    always #2 clk = ~clk;

    uart_irq_router u_dut (
        .clk(clk), .rst_n(rst_n),
        .set_we(set_we), .set_wdata(set_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_frame_err(ev_frame_err), .ev_overrun(ev_overrun),
        .ev_parity_err(ev_parity_err), .ev_rx_ready(ev_rx_ready),
        .ev_rx_is_addr(ev_rx_is_addr), .ev_tx_ready(ev_tx_ready),
        .ev_wakeup(ev_wakeup), .ev_break(ev_break),
        .irq_ack(irq_ack), .irq_req(irq_req),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
    );

    typedef struct {
        logic [6:0]  irq;
        logic        rxd;
        logic        txd;
        logic [31:0] rd;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;
    logic [31:0] m_en = '0;
    logic [6:0]  m_irq = '0;

    // Reference model: computes the expected state after the next edge.
    task automatic step(input string tag);
        exp_t        e;
        logic [31:0] sv, cv;
        logic [6:0]  hit;
        logic        rxd, txd, rx_to_dma;
        sv = set_we ? (set_wdata & MASK) : '0;
        cv = clr_we ? clr_wdata : '0;
        hit = '0;
        hit[6] = ev_frame_err  & m_en[26];
        hit[5] = ev_overrun    & m_en[25];
        hit[4] = ev_parity_err & m_en[24];
        hit[1] = ev_wakeup     & m_en[1];
        hit[0] = ev_break      & m_en[0];
        rx_to_dma = m_en[17] & (~ev_rx_is_addr | m_en[18]);
        rxd = ev_rx_ready & rx_to_dma;
        hit[3] = ev_rx_ready & ~rx_to_dma & m_en[9];
        txd = ev_tx_ready & m_en[16];
        hit[2] = ev_tx_ready & ~m_en[16] & m_en[8];
        m_irq = hit | (m_irq & ~irq_ack);
        m_en  = (m_en | sv) & ~cv & MASK;
        e.irq = m_irq;
        e.rxd = rxd;
        e.txd = txd;
        e.rd  = ((rd_addr == 8'h0C) || (rd_addr == 8'h10)) ? m_en : '0;
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        set_we = 0; clr_we = 0; set_wdata = '0; clr_wdata = '0;
        ev_frame_err = 0; ev_overrun = 0; ev_parity_err = 0;
        ev_rx_ready = 0; ev_rx_is_addr = 0; ev_tx_ready = 0;
        ev_wakeup = 0; ev_break = 0; irq_ack = '0;
    endtask

    // Monitor: compares each expected item one time unit after its edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if (irq_req !== e.irq || rx_dma_req !== e.rxd ||
                tx_dma_req !== e.txd || rd_data !== e.rd) begin
                bad++;
                $display("FAIL %s: irq=%b rxd=%b txd=%b rd=%h expected irq=%b rxd=%b txd=%b rd=%h",
                         e.tag, irq_req, rx_dma_req, tx_dma_req, rd_data,
                         e.irq, e.rxd, e.txd, e.rd);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (irq_req !== '0 || rx_dma_req !== 1'b0 || tx_dma_req !== 1'b0 || rd_data !== '0) begin
            bad++;
            $display("FAIL R1 reset: irq=%b rxd=%b txd=%b rd=%h expected all zero",
                     irq_req, rx_dma_req, tx_dma_req, rd_data);
        end
        rst_n = 1'b1;
        @(negedge clk);
        step("R1 idle after reset");

        // R2 R5: set all ones, only implemented bits stick
        set_we = 1; set_wdata = 32'hFFFF_FFFF; step("R2 R5 set all");
        rd_addr = 8'h10; clr_we = 1; clr_wdata = '0; step("R3 clear zero no effect R6");
        clr_we = 1; clr_wdata = 32'hFFFF_FFFF; step("R3 clear all");
        set_we = 1; set_wdata = '0; step("R2 set zero no effect");
        rd_addr = 8'h14; set_we = 1; set_wdata = 32'h0000_0300; step("R6 other address reads 0");
        rd_addr = 8'h0C;
        // R4: same-cycle set and clear on bit 9
        set_we = 1; set_wdata = 32'h0000_0300; clr_we = 1; clr_wdata = 32'h0000_0200;
        step("R4 clear wins");
        clr_we = 1; clr_wdata = 32'hFFFF_FFFF; step("R3 clear before R7");

        // R7: only framing enabled
        set_we = 1; set_wdata = 32'h0400_0000; step("R7 enable framing");
        ev_frame_err = 1; ev_overrun = 1; ev_parity_err = 1; step("R7 only framing raises");
        step("R8 line holds");
        ev_frame_err = 1; irq_ack = 7'b100_0000; step("R8 event with ack keeps line");
        irq_ack = 7'b100_0000; step("R8 ack retires line");
        set_we = 1; set_wdata = 32'h0300_0000; step("R7 enable overrun parity");
        ev_overrun = 1; ev_parity_err = 1; step("R7 overrun parity raise");
        irq_ack = 7'b011_0000; step("R8 ack both");

        // R9: receive DMA off
        ev_rx_ready = 1; step("R9 rx no enable no irq");
        set_we = 1; set_wdata = 32'h0000_0200; step("R9 enable rx int");
        ev_rx_ready = 1; step("R9 data frame irq");
        irq_ack = 7'b000_1000; step("R8 ack rx");
        ev_rx_ready = 1; ev_rx_is_addr = 1; step("R9 address frame irq");
        irq_ack = 7'b000_1000; step("R8 ack rx again");

        // R10: receive DMA on, all-frames off
        set_we = 1; set_wdata = 32'h0002_0000; step("R10 enable rx dma");
        ev_rx_ready = 1; step("R10 data frame dma");
        step("R14 rx strobe one cycle");
        ev_rx_ready = 1; ev_rx_is_addr = 1; step("R10 address frame irq");
        irq_ack = 7'b000_1000; step("R8 ack rx after R10");

        // R11: all-frames on
        set_we = 1; set_wdata = 32'h0004_0000; step("R11 enable all frames");
        ev_rx_ready = 1; ev_rx_is_addr = 1; step("R11 address frame dma");
        ev_rx_ready = 1; step("R11 data frame dma");
        step("R14 strobe ends");

        // R12: transmit
        ev_tx_ready = 1; step("R12 tx no enable");
        set_we = 1; set_wdata = 32'h0000_0100; step("R12 enable tx int");
        ev_tx_ready = 1; step("R12 tx irq");
        irq_ack = 7'b000_0100; set_we = 1; set_wdata = 32'h0001_0000; step("R12 ack, enable tx dma");
        ev_tx_ready = 1; step("R12 tx dma");
        step("R14 tx strobe one cycle");

        // R13: wakeup and break
        ev_wakeup = 1; ev_break = 1; step("R13 disabled no irq");
        set_we = 1; set_wdata = 32'h0000_0002; step("R13 enable wakeup");
        ev_wakeup = 1; ev_break = 1; step("R13 only wakeup raises");
        set_we = 1; set_wdata = 32'h0000_0001; irq_ack = 7'b000_0010; step("R13 enable break ack wake");
        ev_break = 1; step("R13 break raises");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule